// File: doc/BRIEF.md
# Indirect Prefetch Confidence Table

This block is the decision point of a prefetcher that learns both sequential streams and indirect access patterns of the form `base + (index << shift)`. It keeps a small set-associative table of entries, each looked up by a tag that the surrounding logic derives from the demand access (for example, from the load instruction). Every entry carries two independent confidence trackers. The stream tracker counts consecutive cache-line-sequential accesses. The indirect tracker holds a base address and a shift, which an external pattern detector supplies. It also holds the current index value and a 3-bit saturating confidence counter.

Demand accesses update the stream tracker of their own entry. They also raise the indirect confidence of any enabled entry whose predicted address they hit. Index updates move an entry to a new index value. They lower its confidence if the old index value drew no matching access, and they send a notice to the pattern detector. Once confidence is high enough, the block emits prefetch addresses one per cycle through a single-entry valid/ready output register.

Top module: `ipf_conf_table`

## Requirements
- R1: After reset, `pf_valid` and `note_valid` are 0 and every table entry is invalid.
- R2: A demand access whose address equals `base + shifted index` of a valid, enabled entry increments that entry's indirect confidence and marks the entry as matched for its current index.
- R3: Indirect confidence is 3 bits and saturates at 7 and at 0. An index update on an entry whose matched flag is clear decrements it. The update then clears the matched flag.
- R4: A demand access that hits its entry and whose address is the entry's last address plus 64 with the same secure bit raises the stream count, which saturates at 3. Any other hitting access resets the count to 0. Each access that leaves the count at 3 starts a stream burst beginning at its own address plus 64.
- R5: An index update whose tag hits the table stores the new index and produces a one-cycle `note_valid` with that tag and index on the following cycle. An index update that misses the table is ignored.
- R6: On an index update of an enabled entry whose confidence after the update is at least 4, one prefetch is issued at `base + (index << shift)`. `shift` is a 4-bit two's-complement value, and a negative value shifts right by its magnitude.
- R7: A burst issues at most 3 addresses (the stream length of 4 is capped). The addresses go out one per cycle, 64 bytes apart, in ascending order. A new triggering event replaces any burst still running.
- R8: An invalidate whose tag hits clears every field of that entry. The tag then misses, and the entry's learned state and confidence are gone.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_addr` holds. Burst addresses produced during the stall are dropped, not queued.
- R10: At most one operation is accepted per cycle, with priority invalidate, learn, index update, access. The lower-priority inputs in that cycle are ignored, and the table changes only on an accepted operation.
- R11: The table is 4-way set associative, with the set given by tag bits [1:0]. An access miss allocates an invalid way first, otherwise the least recently accessed way. Only demand accesses count as use.
- R12: A learn operation whose tag hits sets the entry's enable bit, base and shift, and resets its confidence and matched flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Demand access present |
| acc_tag | input | 12 | Lookup tag of the access |
| acc_addr | input | 32 | Byte address of the access |
| acc_secure | input | 1 | Secure attribute of the access |
| idx_valid | input | 1 | Index update present |
| idx_tag | input | 12 | Tag of the entry to update |
| idx_value | input | 16 | New index value |
| lrn_valid | input | 1 | Learned pattern present |
| lrn_tag | input | 12 | Tag of the entry to enable |
| lrn_base | input | 32 | Learned base address |
| lrn_shift | input | 4 | Learned shift, two's complement |
| inv_valid | input | 1 | Invalidate request |
| inv_tag | input | 12 | Tag to invalidate |
| pf_valid | output | 1 | Prefetch address valid |
| pf_ready | input | 1 | Consumer accepts the prefetch |
| pf_addr | output | 32 | Prefetch address |
| note_valid | output | 1 | New-index notice to the pattern detector |
| note_tag | output | 12 | Tag of the updated entry |
| note_index | output | 16 | Index value just stored |

## Verification
Assertions check four things on every cycle. The output register must hold its address while stalled. A running burst never holds more than the cap. A notice only ever follows an accepted index update. No entry changes in a cycle without an accepted operation. The arithmetic behaviour needs the bench's scenarios: saturation at both ends of the confidence counter, right shifts for negative shift values, stream-count reset on a secure change, LRU victim choice, operation priority, and the dropping of burst addresses during a stall. Each of these is only visible as a particular sequence of prefetch addresses and notices.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
    localparam int ADDR_W  = 32;
    localparam int TAG_W   = 12;
    localparam int IDX_W   = 16;
    localparam int SHIFT_W = 4;
    localparam int CONF_W  = 3;
    localparam int SCNT_W  = 3;
    localparam int LINE_W  = 6;
    localparam int CNT_W   = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    localparam addr_t LINE_BYTES = addr_t'(1) << LINE_W;

    typedef struct packed {
        logic                       valid;
        logic [TAG_W-1:0]           tag;
        addr_t                      last;
        logic                       secure;
        logic [SCNT_W-1:0]          scnt;
        logic                       enabled;
        logic [IDX_W-1:0]           index;
        addr_t                      base;
        logic signed [SHIFT_W-1:0]  shift;
        logic [CONF_W-1:0]          conf;
        logic                       matched;
    } entry_t;

    typedef struct packed {
        logic             valid;
        addr_t            start;
        logic [CNT_W-1:0] count;
    } burst_req_t;

    function automatic addr_t predict(addr_t base, logic [IDX_W-1:0] idx,
                                      logic signed [SHIFT_W-1:0] sh);
        addr_t wide;
        logic [SHIFT_W-1:0] mag;
        wide = addr_t'(idx);
        if (sh < 0) begin
            mag = -sh;
            return base + (wide >> mag);
        end
        mag = sh;
        return base + (wide << mag);
    endfunction

    function automatic logic [CONF_W-1:0] sat_inc(logic [CONF_W-1:0] x);
        return (x == {CONF_W{1'b1}}) ? x : x + 1'b1;
    endfunction

    function automatic logic [CONF_W-1:0] sat_dec(logic [CONF_W-1:0] x);
        return (x == '0) ? x : x - 1'b1;
    endfunction
endpackage

// File: rtl/ipf_store.sv
module ipf_store
    import ipf_pkg::*;
#(
    parameter int SET_W         = 2,
    parameter int WAYS          = 4,
    parameter int IND_THRESH    = 4,
    parameter int STREAM_THRESH = 3,
    parameter int STREAM_DIST   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_valid,
    input  logic [TAG_W-1:0]          acc_tag,
    input  addr_t                     acc_addr,
    input  logic                      acc_secure,
    input  logic                      idx_valid,
    input  logic [TAG_W-1:0]          idx_tag,
    input  logic [IDX_W-1:0]          idx_value,
    input  logic                      lrn_valid,
    input  logic [TAG_W-1:0]          lrn_tag,
    input  addr_t                     lrn_base,
    input  logic signed [SHIFT_W-1:0] lrn_shift,
    input  logic                      inv_valid,
    input  logic [TAG_W-1:0]          inv_tag,
    output burst_req_t                req,
    output logic                      note_valid,
    output logic [TAG_W-1:0]          note_tag,
    output logic [IDX_W-1:0]          note_index
);
    localparam int SETS  = 1 << SET_W;
    localparam int NENT  = SETS * WAYS;
    localparam int WAY_W = $clog2(WAYS);

    entry_t           ent   [NENT];
    entry_t           ent_n [NENT];
    logic [WAY_W-1:0] age   [NENT];
    logic [WAY_W-1:0] age_n [NENT];
    logic [NENT-1:0]  pmatch;

    // one operation per cycle, fixed priority
    logic op_inv, op_lrn, op_idx, op_acc;
    assign op_inv = inv_valid;
    assign op_lrn = lrn_valid && !inv_valid;
    assign op_idx = idx_valid && !inv_valid && !lrn_valid;
    assign op_acc = acc_valid && !inv_valid && !lrn_valid && !idx_valid;

    logic [TAG_W-1:0] ltag;
    logic [SET_W-1:0] lset;
    assign ltag = op_inv ? inv_tag : op_lrn ? lrn_tag : op_idx ? idx_tag : acc_tag;
    assign lset = ltag[SET_W-1:0];

    // predicted-address comparators, one per entry
    for (genvar g = 0; g < NENT; g++) begin : g_match
        assign pmatch[g] = ent[g].valid && ent[g].enabled &&
                           (predict(ent[g].base, ent[g].index, ent[g].shift) == acc_addr);
    end

    int   base_ix, hway, vway, hix, vix, tway;
    logic hit, vfound, touch, seq_ok;
    logic note_n;
    logic [SCNT_W-1:0] scnt_new;
    logic [CONF_W-1:0] conf_new;

    always_comb begin
        ent_n    = ent;
        age_n    = age;
        req      = '0;
        note_n   = 1'b0;
        hit      = 1'b0;
        hway     = 0;
        vfound   = 1'b0;
        vway     = 0;
        touch    = 1'b0;
        tway     = 0;
        seq_ok   = 1'b0;
        scnt_new = '0;
        conf_new = '0;
        base_ix  = int'(lset) * WAYS;

        for (int w = 0; w < WAYS; w++) begin
            if (ent[base_ix + w].valid && ent[base_ix + w].tag == ltag) begin
                hit  = 1'b1;
                hway = w;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!ent[base_ix + w].valid && !vfound) begin
                vfound = 1'b1;
                vway   = w;
            end
        end
        if (!vfound) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[base_ix + w] == WAY_W'(WAYS - 1)) vway = w;
            end
        end
        hix = base_ix + hway;
        vix = base_ix + vway;

        // R2: confidence from accesses that land on a prediction
        for (int i = 0; i < NENT; i++) begin
            if (op_acc && pmatch[i]) begin
                ent_n[i].conf    = sat_inc(ent[i].conf);
                ent_n[i].matched = 1'b1;
            end
        end

        if (op_inv && hit) begin
            ent_n[hix] = '0;
        end else if (op_lrn && hit) begin
            ent_n[hix].enabled = 1'b1;
            ent_n[hix].base    = lrn_base;
            ent_n[hix].shift   = lrn_shift;
            ent_n[hix].conf    = '0;
            ent_n[hix].matched = 1'b0;
        end else if (op_idx && hit) begin
            conf_new = ent[hix].matched ? ent[hix].conf : sat_dec(ent[hix].conf);
            ent_n[hix].conf    = conf_new;
            ent_n[hix].matched = 1'b0;
            ent_n[hix].index   = idx_value;
            note_n = 1'b1;
            if (ent[hix].enabled && conf_new >= CONF_W'(IND_THRESH)) begin
                req.valid = 1'b1;
                req.start = predict(ent[hix].base, idx_value, ent[hix].shift);
                req.count = CNT_W'(1);
            end
        end else if (op_acc && hit) begin
            seq_ok = (acc_addr == ent[hix].last + LINE_BYTES) &&
                     (acc_secure == ent[hix].secure);
            if (!seq_ok)
                scnt_new = '0;
            else if (ent[hix].scnt >= SCNT_W'(STREAM_THRESH))
                scnt_new = SCNT_W'(STREAM_THRESH);
            else
                scnt_new = ent[hix].scnt + 1'b1;
            ent_n[hix].scnt   = scnt_new;
            ent_n[hix].last   = acc_addr;
            ent_n[hix].secure = acc_secure;
            if (seq_ok && scnt_new == SCNT_W'(STREAM_THRESH)) begin
                req.valid = 1'b1;
                req.start = acc_addr + LINE_BYTES;
                req.count = CNT_W'(STREAM_DIST);
            end
            touch = 1'b1;
            tway  = hway;
        end else if (op_acc) begin
            ent_n[vix]        = '0;
            ent_n[vix].valid  = 1'b1;
            ent_n[vix].tag    = acc_tag;
            ent_n[vix].last   = acc_addr;
            ent_n[vix].secure = acc_secure;
            touch = 1'b1;
            tway  = vway;
        end

        // R11: age ranks, 0 = most recent
        if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[base_ix + w] < age[base_ix + tway])
                    age_n[base_ix + w] = age[base_ix + w] + 1'b1;
            end
            age_n[base_ix + tway] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) begin
                ent[i] <= '0;
                age[i] <= WAY_W'(i % WAYS);
            end
            note_valid <= 1'b0;
            note_tag   <= '0;
            note_index <= '0;
        end else begin
            ent        <= ent_n;
            age        <= age_n;
            note_valid <= note_n;
            note_tag   <= idx_tag;
            note_index <= idx_value;
        end
    end

    // R5: a notice only ever follows an index update
    p_notice_r5: assert property (@(posedge clk) disable iff (rst)
        note_valid |-> $past(idx_valid));

    for (genvar g = 0; g < NENT; g++) begin : g_quiet
        // R10: no operation, no change to any entry
        p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
            !(acc_valid || idx_valid || lrn_valid || inv_valid) |=> $stable(ent[g]));
    end
endmodule

// File: rtl/ipf_burst.sv
module ipf_burst
    import ipf_pkg::*;
#(
    parameter int MAX_DIST = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  burst_req_t req,
    input  logic       pf_ready,
    output logic       pf_valid,
    output addr_t      pf_addr
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_DIST);

    addr_t            cur;
    logic [CNT_W-1:0] remain;
    logic             cand, free;

    assign cand = (remain != '0);
    assign free = !pf_valid || pf_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            remain   <= '0;
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            if (req.valid) begin
                cur    <= req.start;
                remain <= (req.count > CAP) ? CAP : req.count;
            end else if (cand) begin
                cur    <= cur + LINE_BYTES;
                remain <= remain - 1'b1;
            end
            // a candidate that finds the register busy is dropped
            if (cand && free) begin
                pf_valid <= 1'b1;
                pf_addr  <= cur;
            end else if (pf_ready) begin
                pf_valid <= 1'b0;
            end
        end
    end

    p_cap_r7: assert property (@(posedge clk) disable iff (rst)
        remain <= CAP);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));
endmodule

// File: rtl/ipf_conf_table.sv
module ipf_conf_table
    import ipf_pkg::*;
#(
    parameter int SET_W         = 2,
    parameter int WAYS          = 4,
    parameter int IND_THRESH    = 4,
    parameter int STREAM_THRESH = 3,
    parameter int STREAM_DIST   = 4,
    parameter int MAX_DIST      = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_valid,
    input  logic [TAG_W-1:0]          acc_tag,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic                      acc_secure,
    input  logic                      idx_valid,
    input  logic [TAG_W-1:0]          idx_tag,
    input  logic [IDX_W-1:0]          idx_value,
    input  logic                      lrn_valid,
    input  logic [TAG_W-1:0]          lrn_tag,
    input  logic [ADDR_W-1:0]         lrn_base,
    input  logic signed [SHIFT_W-1:0] lrn_shift,
    input  logic                      inv_valid,
    input  logic [TAG_W-1:0]          inv_tag,
    output logic                      pf_valid,
    input  logic                      pf_ready,
    output logic [ADDR_W-1:0]         pf_addr,
    output logic                      note_valid,
    output logic [TAG_W-1:0]          note_tag,
    output logic [IDX_W-1:0]          note_index
);
    burst_req_t req;

    ipf_store #(
        .SET_W(SET_W), .WAYS(WAYS), .IND_THRESH(IND_THRESH),
        .STREAM_THRESH(STREAM_THRESH), .STREAM_DIST(STREAM_DIST)
    ) u_store (
        .clk, .rst,
        .acc_valid, .acc_tag, .acc_addr, .acc_secure,
        .idx_valid, .idx_tag, .idx_value,
        .lrn_valid, .lrn_tag, .lrn_base, .lrn_shift,
        .inv_valid, .inv_tag,
        .req,
        .note_valid, .note_tag, .note_index
    );

    ipf_burst #(.MAX_DIST(MAX_DIST)) u_burst (
        .clk, .rst, .req, .pf_ready, .pf_valid, .pf_addr
    );
endmodule

// File: tb/ipf_conf_table_test.sv
`timescale 1ns/1ps
module ipf_conf_table_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 0, acc_secure = 0;
    logic [11:0] acc_tag = 0;
    logic [31:0] acc_addr = 0;
    logic        idx_valid = 0;
    logic [11:0] idx_tag = 0;
    logic [15:0] idx_value = 0;
    logic        lrn_valid = 0;
    logic [11:0] lrn_tag = 0;
    logic [31:0] lrn_base = 0;
    logic [3:0]  lrn_shift = 0;
    logic        inv_valid = 0;
    logic [11:0] inv_tag = 0;
    logic        pf_valid, pf_ready = 1'b1;
    logic [31:0] pf_addr;
    logic        note_valid;
    logic [11:0] note_tag;
    logic [15:0] note_index;

    int checks = 0;
    int errors = 0;
    logic [31:0] pfq[$];
    logic [31:0] expq[$];
    logic [27:0] noteq[$];

    always #2 clk = ~clk;

    ipf_conf_table uut (
        .clk, .rst, .acc_valid, .acc_tag, .acc_addr, .acc_secure,
        .idx_valid, .idx_tag, .idx_value, .lrn_valid, .lrn_tag, .lrn_base,
        .lrn_shift, .inv_valid, .inv_tag, .pf_valid, .pf_ready, .pf_addr,
        .note_valid, .note_tag, .note_index
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (pf_valid && pf_ready) pfq.push_back(pf_addr);
            if (note_valid) noteq.push_back({note_tag, note_index});
        end
    end

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic do_acc(input logic [11:0] t, input logic [31:0] a, input logic s);
        @(posedge clk); #1;
        acc_valid = 1; acc_tag = t; acc_addr = a; acc_secure = s;
        @(posedge clk); #1;
        acc_valid = 0;
        settle();
    endtask

    task automatic do_idx(input logic [11:0] t, input logic [15:0] v);
        @(posedge clk); #1;
        idx_valid = 1; idx_tag = t; idx_value = v;
        @(posedge clk); #1;
        idx_valid = 0;
        settle();
    endtask

    task automatic do_lrn(input logic [11:0] t, input logic [31:0] b, input logic [3:0] sh);
        @(posedge clk); #1;
        lrn_valid = 1; lrn_tag = t; lrn_base = b; lrn_shift = sh;
        @(posedge clk); #1;
        lrn_valid = 0;
        settle();
    endtask

    task automatic do_inv(input logic [11:0] t);
        @(posedge clk); #1;
        inv_valid = 1; inv_tag = t;
        @(posedge clk); #1;
        inv_valid = 0;
        settle();
    endtask

    // expected address of an indirect prefetch (R6)
    function automatic logic [31:0] model_pred(logic [31:0] b, logic [15:0] i, logic [3:0] sh);
        if (sh[3]) return b + ({16'd0, i} >> (5'd16 - {1'b0, sh}));
        return b + ({16'd0, i} << sh);
    endfunction

    // expected stream burst after an access at address a (R4, R7)
    task automatic expect_stream(input logic [31:0] a);
        for (int k = 1; k <= 3; k++) expq.push_back(a + 32'(k * 64));
    endtask

    task automatic check_pf(input string r);
        checks++;
        if (pfq.size() != expq.size()) begin
            errors++;
            $display("FAIL %s: prefetch count actual %0d expected %0d", r, pfq.size(), expq.size());
        end else begin
            for (int k = 0; k < expq.size(); k++) begin
                if (pfq[k] !== expq[k]) begin
                    errors++;
                    $display("FAIL %s: prefetch %0d actual %h expected %h", r, k, pfq[k], expq[k]);
                    break;
                end
            end
        end
        pfq.delete();
        expq.delete();
    endtask

    task automatic check_note(input string r, input int n, input logic [11:0] t, input logic [15:0] v);
        checks++;
        if (noteq.size() != n) begin
            errors++;
            $display("FAIL %s: notice count actual %0d expected %0d", r, noteq.size(), n);
        end else if (n == 1 && noteq[0] !== {t, v}) begin
            errors++;
            $display("FAIL %s: notice actual %h expected %h", r, noteq[0], {t, v});
        end
        noteq.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        checks++;
        if (pf_valid !== 1'b0 || note_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual %b%b expected 00", pf_valid, note_valid);
        end
        do_idx(12'h005, 16'd1);
        check_note("R1 empty table after reset", 0, 0, 0);

        // R4 stream detection, R7 cap and order
        do_acc(12'h005, 32'h1000, 0);
        do_acc(12'h005, 32'h1040, 0);
        do_acc(12'h005, 32'h1080, 0);
        check_pf("R4 below stream threshold");
        do_acc(12'h005, 32'h10C0, 0);
        expect_stream(32'h10C0);
        check_pf("R7 capped stream burst");
        do_acc(12'h005, 32'h1100, 0);
        expect_stream(32'h1100);
        check_pf("R4 saturated stream count");
        do_acc(12'h005, 32'h2000, 0);
        do_acc(12'h005, 32'h2040, 0);
        do_acc(12'h005, 32'h2080, 1);
        do_acc(12'h005, 32'h20C0, 1);
        do_acc(12'h005, 32'h2100, 1);
        check_pf("R4 reset by jump and secure change");
        do_acc(12'h005, 32'h2140, 1);
        expect_stream(32'h2140);
        check_pf("R4 stream after restart");

        // R12, R5, R2, R3, R6 indirect confidence
        do_acc(12'h009, 32'h9000, 0);
        do_lrn(12'h009, 32'h40000, 4'd2);
        do_idx(12'h009, 16'd10);
        check_note("R5 notice on index update", 1, 12'h009, 16'd10);
        check_pf("R3 floor at zero, no prefetch");
        for (int k = 0; k < 4; k++) do_acc(12'h020, model_pred(32'h40000, 16'd10, 4'd2), 0);
        check_pf("R2 matches alone issue nothing");
        do_idx(12'h009, 16'd11);
        expq.push_back(model_pred(32'h40000, 16'd11, 4'd2));
        check_pf("R6 threshold reached");
        noteq.delete();
        do_idx(12'h009, 16'd12);
        check_pf("R3 decrement without match");
        do_acc(12'h020, model_pred(32'h40000, 16'd12, 4'd2), 0);
        do_idx(12'h009, 16'd13);
        expq.push_back(model_pred(32'h40000, 16'd13, 4'd2));
        check_pf("R2 single match restores threshold");
        for (int k = 0; k < 6; k++) do_acc(12'h020, model_pred(32'h40000, 16'd13, 4'd2), 0);
        for (int v = 14; v <= 17; v++) begin
            do_idx(12'h009, 16'(v));
            expq.push_back(model_pred(32'h40000, 16'(v), 4'd2));
            check_pf("R3 saturation at seven");
        end
        do_idx(12'h009, 16'd18);
        check_pf("R3 decay below threshold");
        noteq.delete();

        // R6 negative shift
        do_acc(12'h031, 32'hA000, 0);
        do_lrn(12'h031, 32'h80000, 4'hE);
        do_idx(12'h031, 16'd64);
        for (int k = 0; k < 4; k++) do_acc(12'h020, model_pred(32'h80000, 16'd64, 4'hE), 0);
        do_idx(12'h031, 16'd128);
        expq.push_back(model_pred(32'h80000, 16'd128, 4'hE));
        check_pf("R6 right shift");
        noteq.delete();

        // R8 invalidate
        do_inv(12'h009);
        do_idx(12'h009, 16'd20);
        check_note("R8 invalidated tag misses", 0, 0, 0);
        check_pf("R8 no prefetch after invalidate");
        do_acc(12'h009, 32'h9000, 0);
        do_idx(12'h009, 16'd21);
        check_note("R8 realloc notice", 1, 12'h009, 16'd21);
        check_pf("R8 learned state cleared");

        // R10 priority
        @(posedge clk); #1;
        lrn_valid = 1; lrn_tag = 12'h031; lrn_base = 32'h80000; lrn_shift = 4'd0;
        idx_valid = 1; idx_tag = 12'h031; idx_value = 16'd7;
        @(posedge clk); #1;
        lrn_valid = 0; idx_valid = 0;
        settle();
        check_note("R10 learn beats index", 0, 0, 0);
        @(posedge clk); #1;
        idx_valid = 1; idx_tag = 12'h031; idx_value = 16'd9;
        acc_valid = 1; acc_tag = 12'h005; acc_addr = 32'h2180; acc_secure = 1;
        @(posedge clk); #1;
        idx_valid = 0; acc_valid = 0;
        settle();
        check_note("R10 index beats access", 1, 12'h031, 16'd9);
        check_pf("R10 access ignored");
        do_acc(12'h005, 32'h2180, 1);
        expect_stream(32'h2180);
        check_pf("R10 stream state untouched by ignored access");

        // R11 LRU replacement in set 2
        do_acc(12'h102, 32'h300000, 0);
        do_acc(12'h112, 32'h310000, 0);
        do_acc(12'h122, 32'h320000, 0);
        do_acc(12'h132, 32'h330000, 0);
        do_acc(12'h102, 32'h340000, 0);
        do_acc(12'h142, 32'h350000, 0);
        do_idx(12'h112, 16'd1);
        check_note("R11 LRU way evicted", 0, 0, 0);
        do_idx(12'h102, 16'd2);
        check_note("R11 recently used way kept", 1, 12'h102, 16'd2);
        do_idx(12'h122, 16'd3);
        check_note("R11 other way kept", 1, 12'h122, 16'd3);

        // R9 stall drops
        pf_ready = 0;
        do_acc(12'h203, 32'h5000, 0);
        do_acc(12'h203, 32'h5040, 0);
        do_acc(12'h203, 32'h5080, 0);
        do_acc(12'h203, 32'h50C0, 0);
        @(negedge clk);
        checks++;
        if (pf_valid !== 1'b1 || pf_addr !== 32'h5100) begin
            errors++;
            $display("FAIL R9: held output actual %b %h expected 1 %h", pf_valid, pf_addr, 32'h5100);
        end
        @(posedge clk); #1 pf_ready = 1;
        settle();
        expq.push_back(32'h5100);
        check_pf("R9 stalled burst dropped");

        // constrained random streams on fresh tags
        for (int it = 0; it < 30; it++) begin
            logic [11:0] t;
            logic [31:0] b;
            logic        s;
            int          len;
            t   = 12'h800 + 12'(it);
            b   = 32'h1000_0000 | ($urandom & 32'h00FF_FFC0);
            s   = 1'($urandom);
            len = 1 + ($urandom % 6);
            for (int k = 0; k < len; k++) begin
                do_acc(t, b + 32'(k * 64), s);
                if (k >= 3) expect_stream(b + 32'(k * 64));
            end
            check_pf("R4 R7 random stream");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule